// File: doc/BRIEF.md
# Expansion Function Address Decoder with Programmed-BAR Gating

This block holds the configuration registers of one expansion function that owns six base address registers (BARs) and decodes incoming bus addresses against them. Each BAR has a sticky "programmed" flag. A BAR takes part in decoding only while its flag is set. Any configuration write that reaches a BAR sets its flag. Software can also clear or set the flags directly through a flag register.

For BAR4 and BAR5 the block also drives an active-low chip select toward a secondary expansion bus when a redirect bit enables it. Two 32-bit scratchpad registers give firmware somewhere to park values; they play no part in decoding.

The configuration port takes a byte index that must be dword-aligned, 32-bit write data and four byte enables. Reads are combinational from the index. Decode results (`bar_hit`, `bar_cs_n`) are registered. Each BAR covers a fixed power-of-two window. BAR n spans 2^(SIZE_LOG2_BASE+n) bytes, which is 16 bytes for BAR0 up to 512 bytes for BAR5 at the default setting. Register-to-register flow is a single pipeline: configuration write, then register update, then decode. The project has no state machine.

Top module: `xbd_cfg_decoder`

## Requirements
- R1: After reset, every BAR, every programmed flag, the redirect bits and both scratchpads read as zero. `bar_hit` is 000000b and `bar_cs_n` is 11b.
- R2: BAR n is at index 10h, 14h, 18h, 1Ch, 24h or 28h for n = 0..5. A write updates only the bytes whose enable is set (be[k] selects data bits 8k+7:8k). Address bits below 2^(SIZE_LOG2_BASE+n) always read back as 0.
- R3: A write to a BAR index with at least one byte enable set makes that BAR's flag read as 1 from the next cycle. The flag is visible at index 58h, where bit n belongs to BAR n.
- R4: A BAR whose flag is 0 never hits. Writing its flag back to 1 (index 58h, byte 0) restores decoding, and so does writing the BAR again.
- R5: `bar_hit[n]` is 1 in the cycle after an edge where `bus_valid` was 1, flag n was 1, and `bus_addr` matched BAR n on all bits at or above the BAR size. Otherwise `bar_hit[n]` is 0.
- R6: `bar_cs_n[k]` (k = 0 for BAR4, k = 1 for BAR5) is 0 exactly when `bar_hit[4+k]` is 1 and redirect bit k was 1 at the sampling edge. It is 1 in every other case.
- R7: Redirect bits are at index 58h bits 12 (BAR4) and 13 (BAR5) and are written through byte enable 1. In the dword at 58h, bits 7:6, 11:8, 15:14 and 31:16 always read 0, and writes to them are ignored.
- R8: The scratchpads at 60h and 64h are 32-bit registers with byte-enable writes. Their contents do not change any decode result.
- R9: Every other index reads 0 and ignores writes. This covers unimplemented dwords and any index whose low two bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration byte index (dword-aligned) |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_idx` |
| bus_addr | input | 32 | Address to decode |
| bus_valid | input | 1 | Address valid strobe |
| bar_hit | output | 6 | Registered per-BAR hit |
| bar_cs_n | output | 2 | Registered active-low selects for BAR4, BAR5 |

## Verification
Read data is combinational, so the bench sets the index at a falling edge and samples 1 ns later. A configuration write lands at the next rising edge, and both its readback and its effect on decoding are visible from the falling edge that follows. A probed address is registered at one rising edge and its hit and select are sampled 1 ns after that edge. The expected values come from an arithmetic model of the registers. The bench sweeps the whole dword index space, plus edge and outside offsets of every BAR window, with the strobe both on and off.

// File: rtl/xbd_pkg.sv
package xbd_pkg;

    localparam int NUM_BAR  = 6;
    localparam int NUM_CS   = 2;
    localparam int CS_FIRST = 4;

    localparam logic [7:0] IDX_FLAGS = 8'h58;
    localparam logic [7:0] IDX_SCR0  = 8'h60;
    localparam logic [7:0] IDX_SCR1  = 8'h64;

    // Configuration index of each BAR slot
    function automatic logic [7:0] bar_index(input int n);
        case (n)
            0:       return 8'h10;
            1:       return 8'h14;
            2:       return 8'h18;
            3:       return 8'h1C;
            4:       return 8'h24;
            default: return 8'h28;
        endcase
    endfunction

    // Keeps the address bits at or above the window size
    function automatic logic [31:0] bar_mask(input int size_log2);
        return ~((32'd1 << size_log2) - 32'd1);
    endfunction

    function automatic logic [31:0] byte_merge(input logic [31:0] cur,
                                               input logic [31:0] nxt,
                                               input logic [3:0]  be);
        logic [31:0] res;
        res = cur;
        for (int k = 0; k < 4; k++) begin
            if (be[k]) res[8*k +: 8] = nxt[8*k +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/xbd_bar_slot.sv
module xbd_bar_slot
    import xbd_pkg::*;
#(
    parameter logic [7:0] SLOT_IDX  = 8'h10,
    parameter int         SIZE_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_idx,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    input  logic        flag_wr,
    input  logic        flag_wbit,
    input  logic [31:0] bus_addr,
    input  logic        bus_valid,
    output logic [31:0] base_q,
    output logic        flag_q,
    output logic        match
);

    localparam logic [31:0] MASK = bar_mask(SIZE_LOG2);

    logic sel_wr;
    logic bar_wr;

    assign sel_wr = cfg_wr && (cfg_idx == SLOT_IDX);
    assign bar_wr = sel_wr && (cfg_be != 4'b0000);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (sel_wr) begin
                base_q <= byte_merge(base_q, cfg_wdata, cfg_be) & MASK;
            end
            // A BAR write marks the slot programmed and wins over a manual write
            if (bar_wr) begin
                flag_q <= 1'b1;
            end else if (flag_wr) begin
                flag_q <= flag_wbit;
            end
        end
    end

    assign match = bus_valid && flag_q && ((bus_addr & MASK) == base_q);

endmodule

// File: rtl/xbd_misc_regs.sv
module xbd_misc_regs
    import xbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_idx,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [NUM_CS-1:0] rdr_q,
    output logic [31:0]       scr0_q,
    output logic [31:0]       scr1_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_q  <= '0;
            scr0_q <= '0;
            scr1_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_idx == IDX_FLAGS && cfg_be[1]) begin
                rdr_q <= cfg_wdata[8 + CS_FIRST +: NUM_CS];
            end
            if (cfg_idx == IDX_SCR0) begin
                scr0_q <= byte_merge(scr0_q, cfg_wdata, cfg_be);
            end
            if (cfg_idx == IDX_SCR1) begin
                scr1_q <= byte_merge(scr1_q, cfg_wdata, cfg_be);
            end
        end
    end

endmodule

// File: rtl/xbd_rd_mux.sv
module xbd_rd_mux
    import xbd_pkg::*;
(
    input  logic [7:0]                    cfg_idx,
    input  logic [NUM_BAR-1:0][31:0]      base_vec,
    input  logic [NUM_BAR-1:0]            flag_vec,
    input  logic [NUM_CS-1:0]             rdr_vec,
    input  logic [31:0]                   scr0,
    input  logic [31:0]                   scr1,
    output logic [31:0]                   cfg_rdata
);

    always_comb begin
        cfg_rdata = '0;
        for (int n = 0; n < NUM_BAR; n++) begin
            if (cfg_idx == bar_index(n)) cfg_rdata = base_vec[n];
        end
        unique case (cfg_idx)
            IDX_FLAGS: begin
                cfg_rdata[NUM_BAR-1:0]              = flag_vec;
                cfg_rdata[8 + CS_FIRST +: NUM_CS]   = rdr_vec;
            end
            IDX_SCR0:  cfg_rdata = scr0;
            IDX_SCR1:  cfg_rdata = scr1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/xbd_cfg_decoder.sv
module xbd_cfg_decoder
    import xbd_pkg::*;
#(
    parameter int SIZE_LOG2_BASE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [7:0]         cfg_idx,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [31:0]        bus_addr,
    input  logic               bus_valid,
    output logic [NUM_BAR-1:0] bar_hit,
    output logic [NUM_CS-1:0]  bar_cs_n
);

    logic [NUM_BAR-1:0][31:0] base_vec;
    logic [NUM_BAR-1:0]       flag_vec;
    logic [NUM_BAR-1:0]       match_vec;
    logic [NUM_CS-1:0]        rdr_vec;
    logic [31:0]              scr0;
    logic [31:0]              scr1;
    logic                     flag_wr;

    assign flag_wr = cfg_wr && (cfg_idx == IDX_FLAGS) && cfg_be[0];

    for (genvar n = 0; n < NUM_BAR; n++) begin : g_slot
        xbd_bar_slot #(
            .SLOT_IDX  (bar_index(n)),
            .SIZE_LOG2 (SIZE_LOG2_BASE + n)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_wr),
            .cfg_idx   (cfg_idx),
            .cfg_be    (cfg_be),
            .cfg_wdata (cfg_wdata),
            .flag_wr   (flag_wr),
            .flag_wbit (cfg_wdata[n]),
            .bus_addr  (bus_addr),
            .bus_valid (bus_valid),
            .base_q    (base_vec[n]),
            .flag_q    (flag_vec[n]),
            .match     (match_vec[n])
        );
    end

    xbd_misc_regs u_misc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .rdr_q     (rdr_vec),
        .scr0_q    (scr0),
        .scr1_q    (scr1)
    );

    xbd_rd_mux u_rd (
        .cfg_idx   (cfg_idx),
        .base_vec  (base_vec),
        .flag_vec  (flag_vec),
        .rdr_vec   (rdr_vec),
        .scr0      (scr0),
        .scr1      (scr1),
        .cfg_rdata (cfg_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_hit  <= '0;
            bar_cs_n <= '1;
        end else begin
            bar_hit <= match_vec;
            for (int k = 0; k < NUM_CS; k++) begin
                bar_cs_n[k] <= ~(match_vec[CS_FIRST + k] & rdr_vec[k]);
            end
        end
    end

endmodule

// File: rtl/xbd_checker.sv
module xbd_checker
    import xbd_pkg::*;
#(
    parameter int SIZE_LOG2_BASE = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_wr,
    input logic [7:0]               cfg_idx,
    input logic [3:0]               cfg_be,
    input logic [31:0]              cfg_rdata,
    input logic [31:0]              bus_addr,
    input logic                     bus_valid,
    input logic [NUM_BAR-1:0]       bar_hit,
    input logic [NUM_CS-1:0]        bar_cs_n,
    input logic [NUM_BAR-1:0]       flag_vec,
    input logic [NUM_CS-1:0]        rdr_vec,
    input logic [NUM_BAR-1:0][31:0] base_vec
);

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_hit != '0) |-> $past(bus_valid)); // R5

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx >= 8'h68 || cfg_idx == 8'h5C || cfg_idx[1:0] != 2'b00) |-> (cfg_rdata == '0)); // R9

    AST_FLAG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_FLAGS) |-> (cfg_rdata[31:14] == '0 && cfg_rdata[11:6] == '0)); // R7

    for (genvar n = 0; n < NUM_BAR; n++) begin : g_bar
        AST_HIT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            bar_hit[n] |-> $past(flag_vec[n])); // R4

        AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            bar_hit[n] |-> ((($past(bus_addr) ^ $past(base_vec[n])) & bar_mask(SIZE_LOG2_BASE + n)) == '0)); // R5

        AST_BAR_WR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_idx == bar_index(n) && cfg_be != 4'b0000) |=> flag_vec[n]); // R3
    end

    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        AST_CS_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            !bar_cs_n[k] |-> bar_hit[CS_FIRST + k]); // R6

        AST_CS_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
            !bar_cs_n[k] |-> $past(rdr_vec[k])); // R6
    end

endmodule

bind xbd_cfg_decoder xbd_checker #(.SIZE_LOG2_BASE(SIZE_LOG2_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .cfg_be    (cfg_be),
    .cfg_rdata (cfg_rdata),
    .bus_addr  (bus_addr),
    .bus_valid (bus_valid),
    .bar_hit   (bar_hit),
    .bar_cs_n  (bar_cs_n),
    .flag_vec  (flag_vec),
    .rdr_vec   (rdr_vec),
    .base_vec  (base_vec)
);

// File: tb/xbd_cfg_decoder_tb.sv
module xbd_cfg_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LOG2_BASE  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic [5:0]  bar_hit;
    logic [1:0]  bar_cs_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_bar [6];
    logic [5:0]  m_flag;
    logic [1:0]  m_rdr;
    logic [31:0] m_scr [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    xbd_cfg_decoder #(.SIZE_LOG2_BASE(LOG2_BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_addr(bus_addr), .bus_valid(bus_valid),
        .bar_hit(bar_hit), .bar_cs_n(bar_cs_n)
    );

    function automatic logic [7:0] b_idx(input int n);
        return (n < 4) ? 8'(8'h10 + 4*n) : 8'(8'h24 + 4*(n-4));
    endfunction

    function automatic logic [31:0] b_size(input int n);
        return 32'd1 << (LOG2_BASE + n);
    endfunction

    function automatic logic [31:0] b_mask(input int n);
        return ~(b_size(n) - 32'd1);
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = d[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] rd_model(input logic [7:0] idx);
        for (int n = 0; n < 6; n++) if (idx == b_idx(n)) return m_bar[n];
        if (idx == 8'h58) return {18'd0, m_rdr, 6'd0, m_flag};
        if (idx == 8'h60) return m_scr[0];
        if (idx == 8'h64) return m_scr[1];
        return 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_idx = idx; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        for (int n = 0; n < 6; n++) begin
            if (idx == b_idx(n)) begin
                m_bar[n] = mrg(m_bar[n], d, be) & b_mask(n);
                if (be != 0) m_flag[n] = 1'b1;
            end
        end
        if (idx == 8'h58 && be[0]) m_flag = d[5:0];
        if (idx == 8'h58 && be[1]) m_rdr = d[13:12];
        if (idx == 8'h60) m_scr[0] = mrg(m_scr[0], d, be);
        if (idx == 8'h64) m_scr[1] = mrg(m_scr[1], d, be);
    endtask

    task automatic cfg_read(input logic [7:0] idx, input string req);
        @(negedge clk);
        cfg_idx = idx;
        #1;
        chk(req, cfg_rdata, rd_model(idx));
    endtask

    task automatic probe(input logic [31:0] a, input logic v, input string req);
        logic [5:0] eh;
        logic [1:0] ec;
        @(negedge clk);
        bus_addr = a; bus_valid = v;
        for (int n = 0; n < 6; n++)
            eh[n] = v && m_flag[n] && ((a & b_mask(n)) == m_bar[n]);
        for (int k = 0; k < 2; k++) ec[k] = ~(eh[4+k] & m_rdr[k]);
        @(posedge clk);
        #1;
        chk({req, " hit"}, {26'd0, bar_hit}, {26'd0, eh});
        chk({req, " cs_n"}, {30'd0, bar_cs_n}, {30'd0, ec});
    endtask

    task automatic read_sweep(input string req);
        for (int i = 0; i < 256; i += 4) cfg_read(8'(i), req);
    endtask

    task automatic window_sweep(input string req);
        for (int n = 0; n < 6; n++) begin
            probe(m_bar[n], 1'b1, req);
            probe(m_bar[n] + b_size(n) - 1, 1'b1, req);
            probe(m_bar[n] + (b_size(n) >> 1), 1'b1, req);
            probe(m_bar[n] + b_size(n), 1'b1, req);
            probe(m_bar[n] - 1, 1'b1, req);
            probe(m_bar[n], 1'b0, req);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 6; n++) m_bar[n] = '0;
        m_flag = '0; m_rdr = '0; m_scr[0] = '0; m_scr[1] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset hit", {26'd0, bar_hit}, 32'd0);
        chk("R1 reset cs_n", {30'd0, bar_cs_n}, 32'd3);
        rst_n = 1'b1;
        read_sweep("R1 reset readback");
        probe(32'h0, 1'b1, "R4 unprogrammed no hit");

        // R2/R3: program BARs with junk in the low bits
        for (int n = 0; n < 6; n++) begin
            cfg_write(b_idx(n), 32'h4000_0000 + (n << 20) + 32'h0000_0FFF, 4'hF);
            cfg_read(b_idx(n), "R2 BAR readback masked");
            cfg_read(8'h58, "R3 flag set by BAR write");
        end
        cfg_write(b_idx(0), 32'h00AB_0000, 4'b0100);
        cfg_read(b_idx(0), "R2 byte enable partial");
        cfg_write(b_idx(0), 32'h4000_0000, 4'b0100);
        cfg_read(b_idx(0), "R2 byte restore");

        window_sweep("R5 decode no redirect");

        // R6/R7: redirect bits, all byte-1 bits written
        cfg_write(8'h58, 32'hFFFF_FF3F, 4'b0010);
        cfg_read(8'h58, "R7 redirect readback");
        window_sweep("R6 decode both redirect");
        cfg_write(8'h58, 32'h0000_1000, 4'b0010);
        cfg_read(8'h58, "R7 redirect bar4 only");
        window_sweep("R6 decode redirect bar4");

        // R4: manual flag clear and restore
        cfg_write(8'h58, 32'hFFFF_FFC0, 4'b1101);
        cfg_read(8'h58, "R4 flags cleared redirect kept");
        window_sweep("R4 cleared no hit");
        cfg_write(8'h58, 32'h0000_0004, 4'b0001);
        probe(m_bar[2], 1'b1, "R4 manual set restores");
        cfg_write(b_idx(4), 32'h4040_0000, 4'b1000);
        cfg_read(8'h58, "R4 BAR rewrite sets flag");
        window_sweep("R4 partial flags");
        cfg_write(8'h58, 32'h0000_00FF, 4'b0001);
        cfg_read(8'h58, "R7 flag reserved bits");

        // R8: scratchpads
        cfg_write(8'h60, 32'h1234_5678, 4'hF);
        cfg_write(8'h64, 32'h9ABC_DEF0, 4'b0011);
        cfg_read(8'h60, "R8 scratch0");
        cfg_write(8'h64, 32'h4000_0000, 4'b1000);
        cfg_read(8'h64, "R8 scratch1");
        window_sweep("R8 scratch no decode effect");

        // R9: reserved writes
        for (int i = 0; i < 256; i += 4) begin
            logic reserved;
            reserved = 1'b1;
            for (int n = 0; n < 6; n++) if (8'(i) == b_idx(n)) reserved = 1'b0;
            if (i == 8'h58 || i == 8'h60 || i == 8'h64) reserved = 1'b0;
            if (reserved) cfg_write(8'(i), 32'hFFFF_FFFF, 4'hF);
        end
        cfg_write(8'h11, 32'hFFFF_FFFF, 4'hF);
        cfg_write(8'h5A, 32'hFFFF_FFFF, 4'hF);
        read_sweep("R9 reserved ignored");
        cfg_read(8'h11, "R9 unaligned read");
        cfg_read(8'h61, "R9 unaligned read");
        window_sweep("R9 decode unchanged");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule